// File: doc/BRIEF.md
# Sixteen-Line Interrupt Expander

This block gathers sixteen external interrupt request lines into one active-high, level-sensitive request for a host processor. Each line first passes through a two-flop synchronizer. A synchronized line that is high sets a sticky pending bit. The combined request is raised whenever a pending bit is also enabled.

The host controls the block through four 16-bit word registers on a simple synchronous strobe bus. Bit n of every register stands for line n.

- 0x16 holds the sticky pending bits. Writing ones to it acknowledges those lines.
- 0x18 shows the synchronized live lines.
- 0x1A turns enables on for every bit written as one.
- 0x1C turns enables off for every bit written as one.

Reading either 0x1A or 0x1C returns the enable mask. With these addresses the host never needs a read-modify-write, either to change the mask or to acknowledge a line. At start-up the host writes 0xFFFF to 0x1C and then 0xFFFF to 0x16. After that, every line is masked and nothing is pending.

Top module: `irqx_expander`

## Requirements
- R1: After reset the enable mask and all pending bits are 0, `irq_o` is low and `bus_rdata` is 0.
- R2: A line driven high sets its pending bit at the third rising clock edge after the change, because there are two synchronizer flops and then the pending flop. Reads of offset 0x18 return the synchronized live lines whatever the mask holds.
- R3: A pending bit stays set after its line falls. Writing a word to offset 0x16 clears each pending bit whose written bit is 1 and leaves the bits written as 0 unchanged.
- R4: If a synchronized line is high in the same cycle as a write that clears its pending bit, the bit stays set.
- R5: Writing a word to offset 0x1A sets each enable bit whose written bit is 1. Enable bits written as 0 are unchanged.
- R6: Writing a word to offset 0x1C clears each enable bit whose written bit is 1. Enable bits written as 0 are unchanged. Reads of 0x1A and of 0x1C both return the enable mask.
- R7: `irq_o` is high exactly while at least one bit is both pending and enabled. A pending line that is masked does not raise it.
- R8: Writing 0xFFFF to 0x1C and then 0xFFFF to 0x16, with all lines low, leaves the mask and the pending bits at 0 and `irq_o` low.
- R9: Reads of any offset other than 0x16, 0x18, 0x1A and 0x1C return 0. Writes to such offsets change neither the mask nor the pending bits.
- R10: `bus_rdata` is registered. It carries the read value in the cycle after the cycle in which `bus_rd` is sampled high, and it is 0 in every cycle that does not follow a read strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 16 | Asynchronous interrupt request lines |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_rd | input | 1 | Read strobe, sampled on the rising edge |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| irq_o | output | 1 | Combined active-high level request |

## Verification
Each effect is due a fixed number of clock edges after its stimulus:

- A write takes effect at the edge that samples it, and `irq_o` follows at once.
- A change on a line reaches the live register after two edges and the pending bit after three.
- Read data appears one edge after the read strobe.

The bench drives every input on a falling edge and checks on a later falling edge. It counts the rising edges between the two, so the `irq_o` check made two edges after a line rises must still see the request low, and the check one edge later must see it high. A scoreboard queue holds the expected value of each read. The monitor pops an entry only on the falling edge that follows a sampled read strobe.

// File: rtl/irqx_pkg.sv
`timescale 1ns/1ps
package irqx_pkg;
  localparam int unsigned NSRC = 16;
  localparam int unsigned AW   = 8;

  localparam logic [AW-1:0] OFS_PEND  = 8'h16;
  localparam logic [AW-1:0] OFS_LIVE  = 8'h18;
  localparam logic [AW-1:0] OFS_ENON  = 8'h1A;
  localparam logic [AW-1:0] OFS_ENOFF = 8'h1C;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_PEND,
    SEL_LIVE,
    SEL_ENON,
    SEL_ENOFF
  } sel_e;

  function automatic sel_e decode_ofs(input logic [AW-1:0] a);
    sel_e s;
    case (a)
      OFS_PEND:  s = SEL_PEND;
      OFS_LIVE:  s = SEL_LIVE;
      OFS_ENON:  s = SEL_ENON;
      OFS_ENOFF: s = SEL_ENOFF;
      default:   s = SEL_NONE;
    endcase
    return s;
  endfunction

  function automatic logic [NSRC-1:0] serviceable(input logic [NSRC-1:0] pend,
                                                  input logic [NSRC-1:0] en);
    return pend & en;
  endfunction
endpackage

// File: rtl/irqx_sync.sv
`timescale 1ns/1ps
module irqx_sync #(
  parameter int unsigned W      = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    logic [W-1:0] nxt;
    if (k == 0) begin : g_first
      assign nxt = d_i;
    end else begin : g_rest
      assign nxt = stage_q[k-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[k] <= '0;
      else        stage_q[k] <= nxt;
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/irqx_latch.sv
`timescale 1ns/1ps
module irqx_latch #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] pend_o
);
  logic [W-1:0] pend_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        pend_q[i] <= 1'b0;
      else if (set_i[i]) pend_q[i] <= 1'b1;
      else if (clr_i[i]) pend_q[i] <= 1'b0;
    end
  end

  assign pend_o = pend_q;

  // R4
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & $past(set_i)) == $past(set_i)));

  // R3
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_i == '0) && (clr_i == '0)) |=> $stable(pend_q));
endmodule

// File: rtl/irqx_mask.sv
`timescale 1ns/1ps
module irqx_mask #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] on_i,
  input  logic [W-1:0] off_i,
  output logic [W-1:0] en_o
);
  logic [W-1:0] en_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        en_q[i] <= 1'b0;
      else if (on_i[i])  en_q[i] <= 1'b1;
      else if (off_i[i]) en_q[i] <= 1'b0;
    end
  end

  assign en_o = en_q;

  // R5
  en_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (on_i != '0) |=> ((en_q & $past(on_i)) == $past(on_i)));

  // R6
  en_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((off_i != '0) && (on_i == '0)) |=> ((en_q & $past(off_i)) == '0));

  // R5
  en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((on_i == '0) && (off_i == '0)) |=> $stable(en_q));
endmodule

// File: rtl/irqx_regif.sv
`timescale 1ns/1ps
module irqx_regif
  import irqx_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr_i,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [W-1:0]  pend_i,
  input  logic [W-1:0]  live_i,
  input  logic [W-1:0]  en_i,
  output logic [W-1:0]  pend_clr_o,
  output logic [W-1:0]  en_on_o,
  output logic [W-1:0]  en_off_o,
  output logic          hit_o,
  output logic [W-1:0]  rdata_o
);
  sel_e         sel;
  logic [W-1:0] rd_mux;
  logic [W-1:0] rdata_q;

  assign sel   = decode_ofs(addr_i);
  assign hit_o = (sel != SEL_NONE);

  assign pend_clr_o = (wr_i && sel == SEL_PEND)  ? wdata_i : '0;
  assign en_on_o    = (wr_i && sel == SEL_ENON)  ? wdata_i : '0;
  assign en_off_o   = (wr_i && sel == SEL_ENOFF) ? wdata_i : '0;

  always_comb begin
    case (sel)
      SEL_PEND:            rd_mux = pend_i;
      SEL_LIVE:            rd_mux = live_i;
      SEL_ENON, SEL_ENOFF: rd_mux = en_i;
      default:             rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    rdata_q <= '0;
    else if (rd_i) rdata_q <= rd_mux;
    else           rdata_q <= '0;
  end

  assign rdata_o = rdata_q;

  // R10
  rd_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_i |=> (rdata_q == '0));

  // R9
  rd_undec_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && !hit_o) |=> (rdata_q == '0));
endmodule

// File: rtl/irqx_expander.sv
`timescale 1ns/1ps
module irqx_expander
  import irqx_pkg::*;
#(
  parameter int unsigned N_SRC     = NSRC,
  parameter int unsigned SYNC_DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_i,
  input  logic [AW-1:0]    bus_addr,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [N_SRC-1:0] bus_wdata,
  output logic [N_SRC-1:0] bus_rdata,
  output logic             irq_o
);
  logic [N_SRC-1:0] live_w;
  logic [N_SRC-1:0] pend_w;
  logic [N_SRC-1:0] en_w;
  logic [N_SRC-1:0] pend_clr_w;
  logic [N_SRC-1:0] en_on_w;
  logic [N_SRC-1:0] en_off_w;
  logic [N_SRC-1:0] service_w;
  logic             hit_w;

  irqx_sync #(.W(N_SRC), .STAGES(SYNC_DEPTH)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(src_i), .q_o(live_w)
  );

  irqx_latch #(.W(N_SRC)) u_latch (
    .clk(clk), .rst_n(rst_n), .set_i(live_w), .clr_i(pend_clr_w), .pend_o(pend_w)
  );

  irqx_mask #(.W(N_SRC)) u_mask (
    .clk(clk), .rst_n(rst_n), .on_i(en_on_w), .off_i(en_off_w), .en_o(en_w)
  );

  irqx_regif #(.W(N_SRC)) u_regif (
    .clk(clk), .rst_n(rst_n), .addr_i(bus_addr), .wr_i(bus_wr), .rd_i(bus_rd),
    .wdata_i(bus_wdata), .pend_i(pend_w), .live_i(live_w), .en_i(en_w),
    .pend_clr_o(pend_clr_w), .en_on_o(en_on_w), .en_off_o(en_off_w),
    .hit_o(hit_w), .rdata_o(bus_rdata)
  );

  assign service_w = serviceable(pend_w, en_w);
  assign irq_o     = |service_w;

  // R7
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_w == '0) |-> !irq_o);

  // R7
  irq_needs_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (pend_w != '0));

  // R9
  undec_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !hit_w) |=> $stable(en_w));
endmodule

// File: tb/tb_irqx_expander.sv
`timescale 1ns/1ps
module tb_irqx_expander;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] src_i = '0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen = 1'b0;

  always #10 clk = ~clk;

  irqx_expander dut (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(posedge clk) rd_seen <= bus_rd;

  // monitor: pops one expected word for each read strobe seen
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R10: unexpected read data %h", bus_rdata);
      end else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, bus_rdata, e);
      end
    end
  end

  task automatic wait_n(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, input logic [15:0] exp, input string tag);
    @(negedge clk);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 irq", {15'd0, irq_o}, 16'h0000);
    check("R1 rdata", bus_rdata, 16'h0000);
    bus_read(8'h16, 16'h0000, "R1 pend");
    bus_read(8'h1A, 16'h0000, "R1 enable");

    // R5 write-one-to-set enables
    bus_write(8'h1A, 16'h00F0);
    bus_read(8'h1A, 16'h00F0, "R5 set");
    bus_write(8'h1A, 16'h0003);
    bus_read(8'h1A, 16'h00F3, "R5 zeros kept");
    // R6 clear and alias read
    bus_read(8'h1C, 16'h00F3, "R6 alias read");
    bus_write(8'h1C, 16'h0011);
    bus_read(8'h1A, 16'h00E2, "R6 clear");

    // R2 latency: line up at a falling edge, pending after third rising edge
    @(negedge clk);
    src_i = 16'h0021;
    wait_n(2);
    check("R2 irq early", {15'd0, irq_o}, 16'h0000);
    @(negedge clk);
    check("R2 irq due", {15'd0, irq_o}, 16'h0001);
    bus_read(8'h18, 16'h0021, "R2 live");
    @(negedge clk);
    src_i = 16'h0000;
    wait_n(3);
    bus_read(8'h18, 16'h0000, "R2 live low");
    bus_read(8'h16, 16'h0021, "R3 sticky");
    check("R7 irq held", {15'd0, irq_o}, 16'h0001);

    // R3 write-one-to-clear
    bus_write(8'h16, 16'h0001);
    bus_read(8'h16, 16'h0020, "R3 partial clear");
    check("R7 irq enabled bit", {15'd0, irq_o}, 16'h0001);
    bus_write(8'h16, 16'h0020);
    check("R7 irq drop", {15'd0, irq_o}, 16'h0000);

    // R7 masked pending line
    @(negedge clk);
    src_i = 16'h0001;
    @(negedge clk);
    src_i = 16'h0000;
    wait_n(3);
    bus_read(8'h16, 16'h0001, "R2 pulse latched");
    check("R7 masked", {15'd0, irq_o}, 16'h0000);
    bus_write(8'h1A, 16'h0001);
    check("R7 unmask", {15'd0, irq_o}, 16'h0001);
    bus_write(8'h1C, 16'h0001);
    check("R7 remask", {15'd0, irq_o}, 16'h0000);
    bus_read(8'h16, 16'h0001, "R7 pend kept");

    // R4 set wins over clear for a persisting line
    @(negedge clk);
    src_i = 16'h0004;
    wait_n(4);
    bus_write(8'h16, 16'hFFFF);
    bus_read(8'h16, 16'h0004, "R4 set wins");
    @(negedge clk);
    src_i = 16'h0000;
    wait_n(4);
    bus_write(8'h16, 16'h0004);
    bus_read(8'h16, 16'h0000, "R4 cleared later");

    // R9 undecoded offsets
    bus_write(8'h20, 16'hFFFF);
    bus_write(8'h1E, 16'hFFFF);
    bus_read(8'h1A, 16'h00E2, "R9 mask unchanged");
    bus_read(8'h16, 16'h0000, "R9 pend unchanged");
    bus_read(8'h20, 16'h0000, "R9 read zero");
    bus_read(8'h17, 16'h0000, "R9 odd read zero");

    // R10 idle read data
    @(negedge clk);
    check("R10 idle", bus_rdata, 16'h0000);

    // R8 bring-up sequence
    bus_write(8'h1A, 16'hFFFF);
    @(negedge clk);
    src_i = 16'h8100;
    @(negedge clk);
    src_i = 16'h0000;
    wait_n(3);
    check("R8 irq before", {15'd0, irq_o}, 16'h0001);
    bus_write(8'h1C, 16'hFFFF);
    bus_write(8'h16, 16'hFFFF);
    bus_read(8'h1C, 16'h0000, "R8 mask");
    bus_read(8'h16, 16'h0000, "R8 pend");
    check("R8 irq", {15'd0, irq_o}, 16'h0000);

    wait_n(3);
    if (exp_q.size() != 0) begin
      n_cmp++; n_bad++;
      $display("FAIL R10: %0d reads unanswered, expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule